// File: doc/BRIEF.md
# Reset and Output Test-Mode Controller

This block decides when a small peripheral's register space is wiped and how its output pins behave during manufacturing test. Three sources can start a wipe: the power-on reset, an external hardware reset pin, and a self-clearing software request bit. All three end up on one register-clear strobe that the register banks elsewhere in the peripheral consume. A second, independent request bit resets the line-interface circuitry. It holds a recovery flag high for a long, clock-derived interval, about 40 ms by default.

A two-bit test-mode field overrides the functional output-enable and output-value vectors on their way to the pads. One mode floats every pin, including the parallel-port group. Two modes drive the general pins to a fixed level while the parallel-port group keeps working, so the board can still be accessed over that port. Software reaches the control state over a simple synchronous write bus with a combinational read-back.

Top module: `rtc_ctl`

## Requirements
- R1: While the power-on reset or the hardware reset pin is low, `reg_clr` is high and the control register at address 00h reads 00h. After both are high, `reg_clr` falls after the second rising clock edge, through a two-flop synchronizer.
- R2: Pulling `hw_rst_n` low at any time clears the test mode to normal and the line-request bit to 0, and it raises `reg_clr` without waiting for a clock edge.
- R3: A write to address 00h with bit 0 set, while bit 0 reads 0, starts a software clear. `reg_clr` is then high for exactly CLR_CYC cycles, and bit 0 of address 00h reads 1 for those same cycles and 0 afterwards.
- R4: A software clear sets the test-mode field (bits 5:4 of 00h) to 00 and bit 0 of address 01h to 0. Bus writes made while the clear is running have no effect.
- R5: Bits 7:6 and 3:1 of address 00h always read 0, whatever was written to them. Addresses other than 00h and 01h read 00h.
- R6: With test mode 00, every pad output-enable and pad value equals its functional input.
- R7: With test mode 01, every output-enable is 0, for the general pins and for the parallel-port pins alike. The pad values pass through unchanged.
- R8: With test mode 10, every general pin has output-enable 1 and value 0, and the parallel-port pins pass through unchanged.
- R9: With test mode 11, every general pin has output-enable 1 and value 1, and the parallel-port pins pass through unchanged.
- R10: Writing 1 to bit 0 of address 01h while it reads 0 raises `li_recover` for exactly LI_CYC = (CLK_HZ/1e6)·REC_US cycles, starting after that write's clock edge. Writing 1 while the bit already reads 1 starts nothing.
- R11: A new 0-to-1 write of that bit while `li_recover` is high restarts the full LI_CYC count from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_rst_n | input | 1 | External hardware reset pin, active low, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| reg_clr | output | 1 | Register-space clear strobe (busy while high) |
| li_recover | output | 1 | Line-interface reset/recovery in progress |
| fn_gen_oe | input | N_GEN | Functional output-enables, general pins |
| fn_gen_o | input | N_GEN | Functional output values, general pins |
| fn_pp_oe | input | N_PP | Functional output-enables, parallel-port pins |
| fn_pp_o | input | N_PP | Functional output values, parallel-port pins |
| pad_gen_oe | output | N_GEN | Pad output-enables after override, general pins |
| pad_gen_o | output | N_GEN | Pad values after override, general pins |
| pad_pp_oe | output | N_PP | Pad output-enables after override, parallel-port pins |
| pad_pp_o | output | N_PP | Pad values after override, parallel-port pins |

## Verification
The hardest state to reach is a line-interface restart in the middle of a recovery. The request bit has to be written 0 and then 1 again while the timer is still running, and a write of 1 to a bit that already reads 1 must not restart it. The bench shortens the interval through the clock and recovery parameters and makes that sequence partway through the count. It also writes both registers while a software clear is running, to show those writes are dropped. The reference model is compared on every cycle, so the exact cycles where `li_recover` and `reg_clr` fall are checked, not only their levels.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [1:0] {
    TM_NORMAL = 2'b00,
    TM_HIZ    = 2'b01,
    TM_LOW    = 2'b10,
    TM_HIGH   = 2'b11
  } tmode_e;

  localparam int CTL_ADDR = 0;
  localparam int LI_ADDR  = 1;
  localparam int SW_BIT   = 0;
  localparam int TM_LO    = 4;
  localparam int LI_BIT   = 0;

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign sync_n = s2_q;
endmodule

// File: rtl/rtc_down_timer.sv
// Loadable down-counter: busy while nonzero, flushed while sync_n is low.
module rtc_down_timer #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic sync_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!sync_n)             cnt_d = '0;
    else if (start)          cnt_d = CW'(LEN);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/rtc_pin_ovr.sv
module rtc_pin_ovr
  import rtc_pkg::*;
#(
  parameter int W      = 4,
  parameter bit EXEMPT = 1'b0
) (
  input  tmode_e         mode,
  input  logic [W-1:0]   fn_oe,
  input  logic [W-1:0]   fn_o,
  output logic [W-1:0]   pad_oe,
  output logic [W-1:0]   pad_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (EXEMPT) begin : g_exempt
      // only the float mode reaches these pins
      always_comb begin
        pad_o[i]  = fn_o[i];
        pad_oe[i] = (mode == TM_HIZ) ? 1'b0 : fn_oe[i];
      end
    end else begin : g_forced
      always_comb begin
        pad_oe[i] = fn_oe[i];
        pad_o[i]  = fn_o[i];
        case (mode)
          TM_HIZ:  pad_oe[i] = 1'b0;
          TM_LOW:  begin pad_oe[i] = 1'b1; pad_o[i] = 1'b0; end
          TM_HIGH: begin pad_oe[i] = 1'b1; pad_o[i] = 1'b1; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_ctl.sv
module rtc_ctl
  import rtc_pkg::*;
#(
  parameter int N_GEN   = 8,
  parameter int N_PP    = 8,
  parameter int CLR_CYC = 4,
  parameter int CLK_HZ  = 250_000_000,
  parameter int REC_US  = 40_000,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              reg_clr,
  output logic              li_recover,
  input  logic [N_GEN-1:0]  fn_gen_oe,
  input  logic [N_GEN-1:0]  fn_gen_o,
  input  logic [N_PP-1:0]   fn_pp_oe,
  input  logic [N_PP-1:0]   fn_pp_o,
  output logic [N_GEN-1:0]  pad_gen_oe,
  output logic [N_GEN-1:0]  pad_gen_o,
  output logic [N_PP-1:0]   pad_pp_oe,
  output logic [N_PP-1:0]   pad_pp_o
);
  localparam int LI_CYC = (CLK_HZ / 1_000_000) * REC_US;

  logic   arst_n, sync_n;
  logic   wr_ctl, wr_li, sw_start, li_start, clr_active, wipe;
  tmode_e tm_q, tm_d;
  logic   li_q, li_d;
  logic   unused_wdata;

  assign arst_n = rst_n & hw_rst_n;

  rtc_rst_sync u_sync (.clk(clk), .arst_n(arst_n), .sync_n(sync_n));

  // bus decode; writes are dropped while a clear is running
  assign wr_ctl   = bus_we && (bus_addr == ADDR_W'(CTL_ADDR)) && sync_n && !clr_active;
  assign wr_li    = bus_we && (bus_addr == ADDR_W'(LI_ADDR))  && sync_n && !clr_active;
  assign sw_start = wr_ctl && bus_wdata[SW_BIT];
  assign li_start = wr_li && bus_wdata[LI_BIT] && !li_q;
  assign wipe     = !sync_n || clr_active || sw_start;

  rtc_down_timer #(.LEN(CLR_CYC)) u_clr (
    .clk(clk), .arst_n(arst_n), .sync_n(sync_n), .start(sw_start), .busy(clr_active)
  );

  rtc_down_timer #(.LEN(LI_CYC)) u_li (
    .clk(clk), .arst_n(arst_n), .sync_n(sync_n), .start(li_start), .busy(li_recover)
  );

  always_comb begin
    tm_d = tm_q;
    li_d = li_q;
    if (wipe) begin
      tm_d = TM_NORMAL;
      li_d = 1'b0;
    end else begin
      if (wr_ctl) tm_d = tmode_e'(bus_wdata[TM_LO +: 2]);
      if (wr_li)  li_d = bus_wdata[LI_BIT];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      tm_q <= TM_NORMAL;
      li_q <= 1'b0;
    end else begin
      tm_q <= tm_d;
      li_q <= li_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTL_ADDR)) begin
      bus_rdata[SW_BIT]      = clr_active;
      bus_rdata[TM_LO +: 2]  = tm_q;
    end else if (bus_addr == ADDR_W'(LI_ADDR)) begin
      bus_rdata[LI_BIT]      = li_q;
    end
  end

  assign reg_clr      = !sync_n || clr_active;
  assign unused_wdata = ^{bus_wdata[7:6], bus_wdata[3:1]};

  rtc_pin_ovr #(.W(N_GEN), .EXEMPT(1'b0)) u_gen (
    .mode(tm_q), .fn_oe(fn_gen_oe), .fn_o(fn_gen_o), .pad_oe(pad_gen_oe), .pad_o(pad_gen_o)
  );

  rtc_pin_ovr #(.W(N_PP), .EXEMPT(1'b1)) u_pp (
    .mode(tm_q), .fn_oe(fn_pp_oe), .fn_o(fn_pp_o), .pad_oe(pad_pp_oe), .pad_o(pad_pp_o)
  );
endmodule

// File: rtl/rtc_ctl_chk.sv
module rtc_ctl_chk #(
  parameter int N_GEN   = 8,
  parameter int N_PP    = 8,
  parameter int CLR_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_rst_n,
  input logic             sync_n,
  input logic [1:0]       tm,
  input logic             li_q,
  input logic             li_busy,
  input logic             clr_active,
  input logic             reg_clr,
  input logic [N_GEN-1:0] pad_gen_oe,
  input logic [N_GEN-1:0] pad_gen_o,
  input logic [N_PP-1:0]  fn_pp_oe,
  input logic [N_PP-1:0]  fn_pp_o,
  input logic [N_PP-1:0]  pad_pp_oe,
  input logic [N_PP-1:0]  pad_pp_o
);
  int clr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          clr_run <= 0;
    else if (clr_active) clr_run <= clr_run + 1;
    else                 clr_run <= 0;
  end

  p_hw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_rst_n |-> (tm == 2'b00) && reg_clr && !li_q);

  p_clr_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clr_active) && sync_n) |-> (clr_run == CLR_CYC));

  p_clr_wipes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active |-> (tm == 2'b00) && !li_q);

  p_float_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tm == 2'b01) |-> (pad_gen_oe == '0) && (pad_pp_oe == '0));

  p_force_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tm == 2'b10) |-> (&pad_gen_oe) && (pad_gen_o == '0));

  p_force_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tm == 2'b11) |-> (&pad_gen_oe) && (&pad_gen_o));

  // R8 and R9: parallel-port pins keep their functional values
  p_pp_exempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tm[1] |-> (pad_pp_oe == fn_pp_oe) && (pad_pp_o == fn_pp_o));

  p_li_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(li_q) |-> li_busy);
endmodule

bind rtc_ctl rtc_ctl_chk #(.N_GEN(N_GEN), .N_PP(N_PP), .CLR_CYC(CLR_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .sync_n(sync_n),
  .tm(tm_q), .li_q(li_q), .li_busy(li_recover), .clr_active(clr_active),
  .reg_clr(reg_clr), .pad_gen_oe(pad_gen_oe), .pad_gen_o(pad_gen_o),
  .fn_pp_oe(fn_pp_oe), .fn_pp_o(fn_pp_o), .pad_pp_oe(pad_pp_oe), .pad_pp_o(pad_pp_o)
);

// File: tb/sim_rtc_ctl.sv
`timescale 1ns/1ps
module sim_rtc_ctl;
  localparam int NG  = 4;
  localparam int NP  = 3;
  localparam int CLR = 4;
  localparam int HZ  = 1_000_000;
  localparam int RUS = 40;
  localparam int LI  = 40;   // 1 cycle per us at 1 MHz, times 40 us

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, hw_rst_n, bus_we;
  logic [7:0] bus_addr, bus_wdata;
  logic [7:0] bus_rdata;
  logic reg_clr, li_recover;
  logic [NG-1:0] fn_gen_oe, fn_gen_o, pad_gen_oe, pad_gen_o;
  logic [NP-1:0] fn_pp_oe, fn_pp_o, pad_pp_oe, pad_pp_o;

  rtc_ctl #(.N_GEN(NG), .N_PP(NP), .CLR_CYC(CLR), .CLK_HZ(HZ), .REC_US(RUS), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reg_clr(reg_clr), .li_recover(li_recover),
    .fn_gen_oe(fn_gen_oe), .fn_gen_o(fn_gen_o), .fn_pp_oe(fn_pp_oe), .fn_pp_o(fn_pp_o),
    .pad_gen_oe(pad_gen_oe), .pad_gen_o(pad_gen_o), .pad_pp_oe(pad_pp_oe), .pad_pp_o(pad_pp_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  string phase = "R1";

  // behavioural reference model, advanced on each rising edge
  int m_s1, m_s2, m_cnt, m_tm, m_li, m_licnt;
  always @(posedge clk) begin
    int old_s2;
    if (!(rst_n && hw_rst_n)) begin
      m_s1 = 0; m_s2 = 0; m_cnt = 0; m_tm = 0; m_li = 0; m_licnt = 0;
    end else begin
      old_s2 = m_s2; m_s2 = m_s1; m_s1 = 1;
      if (old_s2 == 0) begin
        m_cnt = 0; m_tm = 0; m_li = 0; m_licnt = 0;
      end else if (m_cnt != 0) begin
        m_cnt--; m_tm = 0; m_li = 0;
        if (m_licnt != 0) m_licnt--;
      end else begin
        if (bus_we && bus_addr == 0) begin
          if (bus_wdata[0]) begin m_cnt = CLR; m_tm = 0; m_li = 0; end
          else m_tm = int'(bus_wdata[5:4]);
        end
        if (bus_we && bus_addr == 1) begin
          if (bus_wdata[0] && m_li == 0) m_licnt = LI;
          else if (m_licnt != 0) m_licnt--;
          m_li = int'(bus_wdata[0]);
        end else if (m_licnt != 0) m_licnt--;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [7:0] er;
    logic [NG-1:0] ego, eg;
    logic [NP-1:0] epo, ep;
    logic eclr, eli;
    er = 8'h00;
    if (bus_addr == 0) begin er[0] = (m_cnt != 0); er[5:4] = 2'(m_tm); end
    else if (bus_addr == 1) er[0] = m_li[0];
    eclr = (m_s2 == 0) || (m_cnt != 0);
    eli  = (m_licnt != 0);
    ego = fn_gen_oe; eg = fn_gen_o; epo = fn_pp_oe; ep = fn_pp_o;
    case (m_tm)
      1: begin ego = '0; epo = '0; end
      2: begin ego = '1; eg = '0; end
      3: begin ego = '1; eg = '1; end
      default: ;
    endcase
    chk({phase, " cycle compare"},
        32'({bus_rdata, reg_clr, li_recover, pad_gen_oe, pad_gen_o, pad_pp_oe, pad_pp_o}),
        32'({er, eclr, eli, ego, eg, epo, ep}));
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
  endtask

  task automatic pins(input int seed);
    fn_gen_oe = NG'(seed * 5 + 3); fn_gen_o = NG'(seed * 7 + 1);
    fn_pp_oe  = NP'(seed * 3 + 2); fn_pp_o  = NP'(seed + 5);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hw_rst_n = 1'b1; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
    pins(0);
    // R1: power-on reset and synchronized release
    idle(3);
    chk("R1 clear during reset", 32'(reg_clr), 32'd1);
    chk("R1 reset readback", 32'(bus_rdata), 32'h00);
    rst_n = 1'b1;
    step();
    chk("R1 clear after one edge", 32'(reg_clr), 32'd1);
    step();
    chk("R1 clear released", 32'(reg_clr), 32'd0);

    phase = "R6";
    for (int s = 1; s < 6; s++) begin pins(s); step(); end

    phase = "R5";
    wr(8'h00, 8'hCE);
    chk("R5 reserved bits read 0", 32'(bus_rdata), 32'h00);
    bus_addr = 8'h07; step();
    chk("R5 unmapped address", 32'(bus_rdata), 32'h00);
    bus_addr = 8'h00;

    phase = "R7";
    wr(8'h00, 8'hDE);
    chk("R7 mode readback", 32'(bus_rdata), 32'h10);
    chk("R7 parallel pins float", 32'(pad_pp_oe), 32'h0);
    for (int s = 6; s < 10; s++) begin pins(s); step(); end

    phase = "R8";
    wr(8'h00, 8'h20);
    chk("R8 general low", 32'({pad_gen_oe, pad_gen_o}), 32'({{NG{1'b1}}, {NG{1'b0}}}));
    for (int s = 10; s < 14; s++) begin pins(s); step(); end

    phase = "R9";
    wr(8'h00, 8'h30);
    chk("R9 parallel passthrough", 32'(pad_pp_o), 32'(fn_pp_o));
    for (int s = 14; s < 18; s++) begin pins(s); step(); end

    phase = "R10";
    wr(8'h01, 8'h01);
    chk("R10 recovery started", 32'(li_recover), 32'd1);
    idle(10);
    wr(8'h01, 8'h01);   // bit already 1: no restart
    idle(10);
    phase = "R11";
    wr(8'h01, 8'h00);
    wr(8'h01, 8'h01);   // restart mid-recovery
    idle(30);
    chk("R11 still recovering after restart", 32'(li_recover), 32'd1);
    idle(15);
    chk("R10 recovery ended", 32'(li_recover), 32'd0);

    phase = "R3";
    wr(8'h00, 8'h31);
    chk("R3 request bit reads 1", 32'(bus_rdata), 32'h01);
    chk("R3 strobe high", 32'(reg_clr), 32'd1);
    phase = "R4";
    wr(8'h00, 8'h20);   // ignored during clear
    wr(8'h01, 8'h01);   // ignored during clear
    idle(3);
    chk("R4 mode cleared", 32'(bus_rdata), 32'h00);
    bus_addr = 8'h01; step();
    chk("R4 line bit ignored", 32'(bus_rdata), 32'h00);
    bus_addr = 8'h00;
    phase = "R3";
    wr(8'h00, 8'h01);
    idle(6);

    phase = "R2";
    wr(8'h00, 8'h20);
    wr(8'h01, 8'h01);
    idle(4);
    hw_rst_n = 1'b0;
    step();
    chk("R2 mode cleared", 32'(bus_rdata), 32'h00);
    chk("R2 strobe high", 32'(reg_clr), 32'd1);
    chk("R2 recovery flushed", 32'(li_recover), 32'd0);
    idle(2);
    hw_rst_n = 1'b1;
    idle(4);
    pins(3);
    wr(8'h00, 8'h30);
    idle(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule